// File: doc/BRIEF.md
# PC-Relative Branch Offset Unit

This block converts between a two-byte relative branch and its destination. A branch is an opcode byte followed by a signed 8-bit displacement. The displacement is measured from the address of the instruction that follows the branch, which is the branch address plus two.

In encode mode the block takes the branch address and the wanted destination. It returns the displacement byte, and it raises an error flag when the destination lies outside the reach of one signed byte. In decode mode it takes the branch address and a displacement byte, and it returns the destination address. The arithmetic is combinational. Results are registered and appear one clock after the request. Evaluating the branch condition and fetching instructions are left to the surrounding logic.

Top module: `branch_offset_unit`

## Requirements
- R1: A request presented with `in_valid` high in one cycle produces `out_valid` high in the next cycle. A cycle without `in_valid` produces `out_valid` low in the next cycle.
- R2: In encode mode (`mode` = 0), `off_out` is the low 8 bits of `dest_addr - (br_addr + 2)` when that difference lies in -128..127. A branch at 0xF880 to 0xF840 gives 0xBE, and a branch at 0xF000 to 0xF044 gives 0x42.
- R3: In encode mode, a difference outside -128..127 sets `range_err` to 1 and forces `off_out` to 0x00. The difference is computed without address wrap, so a branch at 0xF000 to 0xF144 (difference 0x142) is flagged.
- R4: The encode range limits are exact. Differences of +127 and -128 are accepted. Differences of +128 and -129 are flagged.
- R5: In decode mode (`mode` = 1), `tgt_out` = `br_addr + 2 + sign_extend(off_in)`. A branch at 0xF880 with 0xBE gives 0xF840.
- R6: The decode sum wraps modulo 2^16. A branch at 0xFFFE with 0x05 gives 0x0005, and a branch at 0x0000 with 0x80 gives 0xFF82.
- R7: A decode result always has `range_err` = 0 and `off_out` = 0x00. An encode result always has `tgt_out` = 0x0000.
- R8: In a cycle after one without `in_valid`, `off_out`, `tgt_out` and `range_err` keep their previous values.
- R9: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 1 | 0 = encode, 1 = decode |
| br_addr | input | 16 | Address of the branch opcode byte |
| dest_addr | input | 16 | Destination address (encode mode) |
| off_in | input | 8 | Displacement byte (decode mode) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| off_out | output | 8 | Encoded displacement byte |
| tgt_out | output | 16 | Decoded destination address |
| range_err | output | 1 | Destination unreachable (encode mode) |

## Verification
The bench targets the exact range edges at +127/+128 and -128/-129. A design with an off-by-one limit would either flag a reachable branch or emit a wrapped byte for an unreachable one. It also covers branches near the top and bottom of the address space. A decoder that drops the modulo wrap or zero-extends the displacement would return a wrong destination there. Finally, the bench mixes encode and decode requests with idle gaps. A result path that leaks the unused mode's value, or that updates without a request, would show stray data on `off_out` or `tgt_out`.

// File: rtl/brofs_pkg.sv
package brofs_pkg;
   typedef enum logic {
      BR_ENCODE = 1'b0,
      BR_DECODE = 1'b1
   } br_mode_e;
endpackage

// File: rtl/brofs_next_addr.sv
module brofs_next_addr #(
   parameter int ADDR_W    = 16,
   parameter int INSTR_LEN = 2
) (
   input  logic [ADDR_W-1:0] br_addr,
   output logic [ADDR_W:0]   next_wide
);
   localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(INSTR_LEN);

   generate
      if (INSTR_LEN < 1) begin : g_bad_len
         $error("brofs_next_addr: INSTR_LEN must be positive");
      end
   endgenerate

   // Unwrapped sum; the decoder drops the carry, the encoder keeps it.
   assign next_wide = {1'b0, br_addr} + STEP;
endmodule

// File: rtl/brofs_encoder.sv
module brofs_encoder #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 8
) (
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic [ADDR_W:0]   next_wide,
   output logic [OFF_W-1:0]  offset,
   output logic              too_far
);
   // Two guard bits: dest spans 0..2^A-1, next spans INSTR_LEN..2^A+INSTR_LEN-1.
   localparam int DIFF_W = ADDR_W + 2;
   localparam int HI_W   = DIFF_W - OFF_W + 1;

   logic [DIFF_W-1:0] diff;
   logic [HI_W-1:0]   upper;

   always_comb begin
      diff  = {2'b00, dest_addr} - {1'b0, next_wide};
      upper = diff[DIFF_W-1:OFF_W-1];
      // Reachable only if every bit above the offset's sign bit equals it.
      too_far = !((upper == '0) || (upper == '1));
      offset  = too_far ? '0 : diff[OFF_W-1:0];
   end
endmodule

// File: rtl/brofs_decoder.sv
module brofs_decoder #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 8
) (
   input  logic [ADDR_W:0]   next_wide,
   input  logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] disp;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp = {{EXT_W{offset[OFF_W-1]}}, offset};
      end else begin : g_full
         assign disp = offset[ADDR_W-1:0];
      end
   endgenerate

   assign target = next_wide[ADDR_W-1:0] + disp;
endmodule

// File: rtl/branch_offset_unit.sv
module branch_offset_unit #(
   parameter int ADDR_W    = 16,
   parameter int OFF_W     = 8,
   parameter int INSTR_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              mode,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic [OFF_W-1:0]  off_in,
   output logic              out_valid,
   output logic [OFF_W-1:0]  off_out,
   output logic [ADDR_W-1:0] tgt_out,
   output logic              range_err
);
   import brofs_pkg::*;

   generate
      if (OFF_W < 2 || OFF_W > ADDR_W) begin : g_bad_off
         $error("branch_offset_unit: OFF_W must lie in 2..ADDR_W");
      end
   endgenerate

   br_mode_e          mode_e;
   logic [ADDR_W:0]   next_wide;
   logic [OFF_W-1:0]  enc_off;
   logic              enc_err;
   logic [ADDR_W-1:0] dec_tgt;
   br_mode_e          mode_q;

   assign mode_e = br_mode_e'(mode);

   brofs_next_addr #(.ADDR_W(ADDR_W), .INSTR_LEN(INSTR_LEN)) u_next (
      .br_addr   (br_addr),
      .next_wide (next_wide)
   );

   brofs_encoder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_enc (
      .dest_addr (dest_addr),
      .next_wide (next_wide),
      .offset    (enc_off),
      .too_far   (enc_err)
   );

   brofs_decoder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
      .next_wide (next_wide),
      .offset    (off_in),
      .target    (dec_tgt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         off_out   <= '0;
         tgt_out   <= '0;
         range_err <= 1'b0;
         mode_q    <= BR_ENCODE;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            mode_q <= mode_e;
            if (mode_e == BR_ENCODE) begin
               off_out   <= enc_off;
               range_err <= enc_err;
               tgt_out   <= '0;
            end else begin
               off_out   <= '0;
               range_err <= 1'b0;
               tgt_out   <= dec_tgt;
            end
         end
      end
   end

   // R1: result strobe trails the request by one cycle
   a_r1_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_follows : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3: an unreachable destination never leaks a displacement
   a_r3_err_zero_off : assert property (@(posedge clk) disable iff (!rst_n)
      range_err |-> off_out == '0);
   // R7: decode results carry no error and no offset
   a_r7_decode_clean : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BR_DECODE) |-> (!range_err && off_out == '0));
   // R8: no request, no change
   a_r8_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(off_out) && $stable(tgt_out) && $stable(range_err)));
endmodule

// File: tb/sim_branch_offset_unit.sv
module sim_branch_offset_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] br_addr = '0;
   logic [15:0] dest_addr = '0;
   logic [7:0]  off_in = '0;
   logic        out_valid;
   logic [7:0]  off_out;
   logic [15:0] tgt_out;
   logic        range_err;

   int tests = 0;
   int fails = 0;

   // behavioural reference state
   int e_valid = 0, e_off = 0, e_tgt = 0, e_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   branch_offset_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .br_addr(br_addr), .dest_addr(dest_addr), .off_in(off_in),
      .out_valid(out_valid), .off_out(off_out), .tgt_out(tgt_out),
      .range_err(range_err)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "out_valid", int'(out_valid), e_valid);
      chk(tag, "off_out",   int'(off_out),   e_off);
      chk(tag, "tgt_out",   int'(tgt_out),   e_tgt);
      chk(tag, "range_err", int'(range_err), e_err);
   endtask

   // one clock: drive at negedge, update model, compare just after posedge
   task automatic step(input bit v, input bit m, input int br, input int dst,
                       input int ofs, input string tag);
      @(negedge clk);
      in_valid  = v;
      mode      = m;
      br_addr   = 16'(br);
      dest_addr = 16'(dst);
      off_in    = 8'(ofs);
      e_valid   = v ? 1 : 0;
      if (v) begin
         if (!m) begin
            int diff;
            diff  = dst - (br + 2);
            e_tgt = 0;
            if (diff < -128 || diff > 127) begin
               e_err = 1; e_off = 0;
            end else begin
               e_err = 0; e_off = diff & 255;
            end
         end else begin
            int s;
            s     = (ofs > 127) ? ofs - 256 : ofs;
            e_tgt = (((br + 2 + s) % 65536) + 65536) % 65536;
            e_off = 0;
            e_err = 0;
         end
      end
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (3) @(posedge clk);
      #1;
      compare("R9");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R1: reference encodes
      step(1, 0, 'hF880, 'hF840, 0, "R2");
      step(1, 0, 'hF000, 'hF044, 0, "R2");
      // R3: unreachable
      step(1, 0, 'hF000, 'hF144, 0, "R3");
      step(0, 0, 0, 0, 0, "R1");
      // R4: exact limits
      step(1, 0, 'h1000, 'h1002 + 127, 0, "R4");
      step(1, 0, 'h1000, 'h1002 + 128, 0, "R4");
      step(1, 0, 'h1000, 'h1002 - 128, 0, "R4");
      step(1, 0, 'h1000, 'h1002 - 129, 0, "R4");
      // R3: no address wrap in encode
      step(1, 0, 'hFFFE, 'h0000, 0, "R3");
      step(1, 0, 'hFFF0, 'hFFFF, 0, "R2");
      // R5 / R6: decodes
      step(1, 1, 'hF880, 0, 'hBE, "R5");
      step(1, 1, 'hF000, 0, 'h42, "R5");
      step(1, 1, 'hFFFE, 0, 'h05, "R6");
      step(1, 1, 'h0000, 0, 'h80, "R6");
      step(1, 1, 'hFFFD, 0, 'h7F, "R6");
      // R8: idle hold after decode, then encode error then idle
      step(0, 0, 'h1234, 'h5678, 'h11, "R8");
      step(0, 1, 'h4321, 'h8765, 'h22, "R8");
      step(1, 0, 'h2000, 'h3000, 'h33, "R3");
      step(0, 1, 'h0000, 'h0000, 'h80, "R8");
      // R7: mode switching back and forth
      step(1, 1, 'h8000, 'h8004, 'h10, "R7");
      step(1, 0, 'h8000, 'h8004, 'h10, "R7");
      // mixed sweep
      for (int i = 0; i < 300; i++) begin
         int br, dst, ofs;
         bit v, m;
         br  = int'($urandom_range(0, 65535));
         dst = (i % 3 == 0) ? int'($urandom_range(0, 65535))
                            : (br + 2 + int'($urandom_range(0, 300)) - 150 + 65536) % 65536;
         ofs = int'($urandom_range(0, 255));
         v   = (i % 5) != 4;
         m   = (i % 2) == 1;
         step(v, m, br, dst, ofs, v ? (m ? "R5" : "R2") : "R8");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule